// File: doc/BRIEF.md
# Sync-Pulse Serial Link

This block sits beside a CPU that produces its own video sync lines, and it uses those lines as a two-way serial channel. In one direction, the CPU sends data by choosing how long each vertical sync pulse lasts. The block counts horizontal sync rising edges inside each low vertical sync period and turns each count into one bit. After eight bits it presents the byte on `rx_data_o` with a one-cycle strobe.

In the other direction, the block drives the CPU's 8-bit input register. While vertical sync is low and nothing is being sent, the register shifts left on every clock and takes a 1 into bit 0. To send a byte, the block waits for vertical sync to fall and starts one clock later. It then shifts the byte in MSB first, one bit for each horizontal sync rising edge.

A pressed button byte (any value other than all ones) is sent one frame at a time for as long as it is held. A key code from the host is sent for `KEY_FRAMES` frames in a row. A key request that arrives while the sender is busy waits in a one-entry buffer.

Top module: `vsync_serial_link`

## Requirements
- R1: After reset, `in_o` is 8'hFF, `rx_valid_o` is 0 and `rx_data_o` is 8'h00.
- R2: The bit period runs from a falling edge of `vsync_i` to its next rising edge. Rising edges of `hsync_i` are counted during that period. A count of 7 gives bit value 0 and a count of 9 gives bit value 1. Each bit shifts the partial byte right and enters at bit 7, so the first bit received ends up in bit 0.
- R3: In the clock after the `vsync_i` rise that completes the eighth valid bit, `rx_valid_o` is high for exactly one cycle and `rx_data_o` holds the byte. The bit counter then starts again from zero.
- R4: Any count other than 7 or 9 clears the partial byte and the bit counter, and raises no strobe. The count saturates at 15 and does not wrap, so a pulse with 23 horizontal edges is invalid.
- R5: While `vsync_i` is high, `in_o` does not change. While `vsync_i` is low and no frame is being sent, `in_o` shifts left by one on every clock and takes a 1 into bit 0.
- R6: A send frame begins at a falling edge of `vsync_i` (that clock still performs the idle shift). It starts one clock later. On each `hsync_i` rising edge while `vsync_i` is low, `in_o` shifts left and takes the send register's MSB into bit 0. The send register then shifts left and refills with 1. With 8 edges `in_o` equals the byte; with 9 edges it equals `{byte[6:0],1}`.
- R7: A key code is reloaded at the start of each frame and sent in `KEY_FRAMES` (default 2) consecutive frames. After that the sender goes idle.
- R8: Whenever the sender is free, it samples `buttons_i`. If the value is not 8'hFF, that value is sent for one frame, and sampling repeats after each frame. Buttons take priority over a buffered key.
- R9: A `key_req_i` pulse is stored in a one-entry buffer if the buffer is empty, and is sent once the sender is free. A request that arrives while the buffer is full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Horizontal sync level, sampled synchronously |
| vsync_i | input | 1 | Vertical sync level; low is the pulse |
| key_req_i | input | 1 | One-cycle request to send `key_code_i` |
| key_code_i | input | 8 | Key code to send |
| buttons_i | input | 8 | Active-low button state; 8'hFF means none pressed |
| in_o | output | 8 | CPU input register contents |
| rx_data_o | output | 8 | Last byte received from the CPU |
| rx_valid_o | output | 1 | One-cycle strobe for a new `rx_data_o` |

## Verification
The receiver is swept over all 256 byte values as 7- and 9-edge pulse trains; each byte needs exactly one strobe and the right value, which exposes bit-order and bit-count errors. Partial bytes are broken by 8-, 0- and 23-edge pulses. The 23-edge case separates a saturating count from one that wraps to 7. The sender is driven with 8-, 9- and 5-edge frames, idle pulses of known length, held buttons overlapping a key request, and three back-to-back key requests. The expected input-register value is computed from a shift model in the bench, so repeat counts, refill bits, priority and buffer drop behaviour are each observed at `in_o`.

// File: rtl/vsync_serial_link.sv
module vsync_serial_link #(
  parameter int BYTE_W     = 8,
  parameter int CNT_W      = 4,
  parameter int ZERO_COUNT = 7,
  parameter int ONE_COUNT  = 9,
  parameter int KEY_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              key_req_i,
  input  logic [BYTE_W-1:0] key_code_i,
  input  logic [BYTE_W-1:0] buttons_i,
  output logic [BYTE_W-1:0] in_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam int FRM_W = $clog2(KEY_FRAMES + 1);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [CNT_W-1:0]  CNT_ZERO = CNT_W'(ZERO_COUNT);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(ONE_COUNT);
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(BYTE_W - 1);
  localparam logic [BYTE_W-1:0] NO_KEYS  = '1;

  typedef enum logic [1:0] {TX_IDLE, TX_ARM, TX_SKIP, TX_SEND} tx_state_t;

  logic hs_q, vs_q;
  wire hs_rise = hsync_i & ~hs_q;
  wire vs_fall = vs_q & ~vsync_i;
  wire vs_rise = ~vs_q & vsync_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b1;
    end else begin
      hs_q <= hsync_i;
      vs_q <= vsync_i;
    end
  end

  // receive side
  logic              measuring;
  logic [CNT_W-1:0]  hcnt;
  logic [BYTE_W-1:0] part;
  logic [BIT_W-1:0]  nbits;

  wire              bit_ok    = (hcnt == CNT_ZERO) || (hcnt == CNT_ONE);
  wire              bit_val   = (hcnt == CNT_ONE);
  wire [BYTE_W-1:0] part_next = {bit_val, part[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      measuring  <= 1'b0;
      hcnt       <= '0;
      part       <= '0;
      nbits      <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (vs_fall) begin
        measuring <= 1'b1;
        hcnt      <= '0;
      end else if (measuring && !vsync_i && hs_rise && hcnt != CNT_MAX) begin
        hcnt <= hcnt + 1'b1;
      end
      if (vs_rise && measuring) begin
        measuring <= 1'b0;
        if (!bit_ok) begin
          part  <= '0;
          nbits <= '0;
        end else if (nbits == LAST_BIT) begin
          rx_data_o  <= part_next;
          rx_valid_o <= 1'b1;
          part       <= '0;
          nbits      <= '0;
        end else begin
          part  <= part_next;
          nbits <= nbits + 1'b1;
        end
      end
    end
  end

  // transmit side
  tx_state_t         st;
  logic [BYTE_W-1:0] job, sh, buf_code;
  logic [FRM_W-1:0]  left;
  logic              buf_full;

  wire sending      = (st == TX_SKIP) || (st == TX_SEND);
  wire frame_done   = sending && vs_rise;
  wire take_buttons = (st == TX_IDLE) && (buttons_i != NO_KEYS);
  wire take_key     = (st == TX_IDLE) && !take_buttons && buf_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      buf_code <= '0;
    end else if (key_req_i && (!buf_full || take_key)) begin
      buf_full <= 1'b1;
      buf_code <= key_code_i;
    end else if (take_key) begin
      buf_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= TX_IDLE;
      job  <= NO_KEYS;
      sh   <= NO_KEYS;
      left <= '0;
    end else begin
      case (st)
        TX_IDLE: begin
          if (take_buttons) begin
            job  <= buttons_i;
            left <= FRM_W'(1);
            st   <= TX_ARM;
          end else if (take_key) begin
            job  <= buf_code;
            left <= FRM_W'(KEY_FRAMES);
            st   <= TX_ARM;
          end
        end
        TX_ARM: begin
          if (vs_fall) begin
            sh <= job;
            st <= TX_SKIP;
          end
        end
        default: begin
          if (frame_done) begin
            if (left == FRM_W'(1)) st <= TX_IDLE;
            else st <= TX_ARM;
            left <= left - 1'b1;
          end else if (st == TX_SKIP) begin
            st <= TX_SEND;
          end else if (hs_rise && !vsync_i) begin
            sh <= {sh[BYTE_W-2:0], 1'b1};
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) in_o <= NO_KEYS;
    else if (!vsync_i) begin
      if (st == TX_SEND && hs_rise) in_o <= {in_o[BYTE_W-2:0], sh[BYTE_W-1]};
      else if (!sending) in_o <= {in_o[BYTE_W-2:0], 1'b1};
    end
  end
endmodule

// File: rtl/vsync_serial_link_chk.sv
module vsync_serial_link_chk #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vsync_i,
  input logic [BYTE_W-1:0] in_o,
  input logic              rx_valid_o,
  input logic              sending,
  input logic [CNT_W-1:0]  hcnt
);
  p_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_i |=> $stable(in_o));

  p_idle_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!vsync_i && !sending) |=> in_o[0]);

  p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  p_strobe_after_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> ($past(vsync_i) && !$past(vsync_i, 2)));

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == '1) |=> (hcnt == '1 || hcnt == '0));
endmodule

bind vsync_serial_link vsync_serial_link_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .in_o(in_o),
  .rx_valid_o(rx_valid_o), .sending(sending), .hcnt(hcnt)
);

// File: tb/vsync_serial_link_test.sv
module vsync_serial_link_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, hsync, vsync, key_req;
  logic [7:0] key_code, buttons, in_v, rx_data;
  logic rx_valid;

  vsync_serial_link uut (
    .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync),
    .key_req_i(key_req), .key_code_i(key_code), .buttons_i(buttons),
    .in_o(in_v), .rx_data_o(rx_data), .rx_valid_o(rx_valid)
  );

  int checks = 0, fails = 0, strobes = 0;
  logic [7:0] last_rx = 8'h00;
  logic [7:0] model_in = 8'hFF;
  bit done = 0;

  always @(negedge clk) if (rst_n && rx_valid) begin
    strobes++;
    last_rx = rx_data;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // vsync low pulse carrying n hsync edges; low for 4 + 2n clocks
  task automatic frame(int n);
    vsync = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      hsync = 1'b1; @(negedge clk);
      hsync = 1'b0; @(negedge clk);
    end
    repeat (2) @(negedge clk);
    vsync = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic rx_byte(logic [7:0] b);
    for (int i = 0; i < 8; i++) frame(b[i] ? 9 : 7);
  endtask

  task automatic send_key(logic [7:0] c);
    key_code = c; key_req = 1'b1;
    @(negedge clk);
    key_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // model of a send frame: one idle shift at the fall, then n MSB-first shifts with 1 refill
  function automatic logic [7:0] send_model(logic [7:0] prev, logic [7:0] b, int n);
    logic [7:0] v, s;
    v = {prev[6:0], 1'b1};
    s = b;
    for (int i = 0; i < n; i++) begin
      v = {v[6:0], s[7]};
      s = {s[6:0], 1'b1};
    end
    return v;
  endfunction

  function automatic logic [7:0] idle_model(logic [7:0] prev, int clocks);
    logic [7:0] v;
    v = prev;
    for (int i = 0; i < clocks; i++) v = {v[6:0], 1'b1};
    return v;
  endfunction

  task automatic tx_frame(string tag, logic [7:0] b, int n);
    frame(n);
    model_in = send_model(model_in, b, n);
    chk(tag, in_v, model_in);
  endtask

  task automatic idle_frame(string tag, int n);
    frame(n);
    model_in = idle_model(model_in, 4 + 2 * n);
    chk(tag, in_v, model_in);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    int s0;
    rst_n = 1'b0; vsync = 1'b1; hsync = 1'b0; key_req = 1'b0;
    key_code = 8'h00; buttons = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 in", in_v, 8'hFF);
    chk("R1 valid", rx_valid, 0);
    chk("R1 data", rx_data, 8'h00);

    frame(0);
    // R2 R3: full byte sweep
    for (int b = 0; b < 256; b++) begin
      s0 = strobes;
      rx_byte(8'(b));
      chk("R2 byte", last_rx, b);
      chk("R3 one strobe", strobes, s0 + 1);
    end
    chk("R5 idle keeps ones", in_v, 8'hFF);
    model_in = 8'hFF;

    // R4: partial bytes broken by invalid counts
    frame(9); frame(9); frame(9); frame(8);
    s0 = strobes;
    rx_byte(8'h00);
    chk("R4 cleared by 8", last_rx, 8'h00);
    chk("R4 strobe count", strobes, s0 + 1);
    frame(7); frame(9); frame(9); frame(23);
    s0 = strobes;
    rx_byte(8'h12);
    chk("R4 saturated 23", last_rx, 8'h12);
    chk("R4 strobe count sat", strobes, s0 + 1);
    s0 = strobes;
    for (int i = 0; i < 7; i++) frame(9);
    frame(0);
    chk("R4 no strobe on invalid", strobes, s0);
    frame(0);

    // R6 R7: key send
    model_in = 8'hFF;
    send_key(8'hC3);
    tx_frame("R6 key frame 1", 8'hC3, 8);
    tx_frame("R7 key frame 2", 8'hC3, 8);
    idle_frame("R7 idle after key", 8);
    send_key(8'h96);
    tx_frame("R6 nine edges", 8'h96, 9);
    chk("R6 refill", in_v, 8'h2D);
    tx_frame("R6 five edges", 8'h96, 5);
    idle_frame("R7 idle after 96", 0);

    // R5: short idle pulse and high hold
    send_key(8'h00);
    tx_frame("R6 zero key 1", 8'h00, 8);
    tx_frame("R6 zero key 2", 8'h00, 8);
    chk("R6 zero byte", in_v, 8'h00);
    vsync = 1'b0;
    repeat (3) @(negedge clk);
    vsync = 1'b1;
    @(negedge clk);
    chk("R5 three idle shifts", in_v, 8'h07);
    repeat (20) @(negedge clk);
    chk("R5 hold while high", in_v, 8'h07);
    model_in = 8'h07;

    // R8: held buttons with a key waiting
    buttons = 8'h5A;
    repeat (2) @(negedge clk);
    tx_frame("R8 button 1", 8'h5A, 8);
    send_key(8'h41);
    tx_frame("R8 button 2 before key", 8'h5A, 8);
    buttons = 8'hFF;
    tx_frame("R8 button 3 sampled", 8'h5A, 8);
    tx_frame("R8 key after buttons 1", 8'h41, 8);
    tx_frame("R8 key after buttons 2", 8'h41, 8);
    idle_frame("R8 idle", 8);

    // R9: buffer of one
    send_key(8'h11);
    send_key(8'h22);
    send_key(8'h33);
    tx_frame("R9 first 1", 8'h11, 8);
    tx_frame("R9 first 2", 8'h11, 8);
    tx_frame("R9 buffered 1", 8'h22, 8);
    tx_frame("R9 buffered 2", 8'h22, 8);
    idle_frame("R9 third dropped", 8);
    chk("R9 final idle", in_v, 8'hFF);

    summary();
  end
endmodule